// File: doc/BRIEF.md
# Graphics aperture page remapper

The block gives a device one linear window of address space, the aperture, and sends each page of that window to any physical page frame. Physical pages may be scattered in memory. To the device the window is one contiguous range. Software divides the single window among its users. The page table lives in on-chip registers, with one entry per aperture page, and each entry holds a valid flag and a physical frame number. Pages are 4096 bytes, so the low 12 address bits pass through without translation.

A device request carries an aperture address on a valid/ready handshake, and the translated result comes back one cycle after acceptance on a second handshake. The result is one of three things: a physical address, a range fault when the address lies outside the window, or an unmapped fault when the entry's valid flag is clear. A host port writes single entries and can clear every valid flag in one cycle. The window is not coherent. Before another agent reads data through it, software raises a flush request. The block stops accepting requests and returns a one-cycle flush-done pulse once nothing is left in flight.

Top module: `aperture_remap`

## Requirements
- R1: A request whose address lies in the window, with a valid entry, returns fault code 0 and physical address {entry frame number, (addr - ap_base)[11:0]}. ap_base must be 4096-byte aligned.
- R2: Latency is fixed. An accepted request (req_valid and req_ready high at a clock edge) gives rsp_valid high from the next cycle on. req_ready equals (not flushing) and (rsp_valid low or rsp_ready high).
- R3: An address with (addr - ap_base), taken modulo 2^ADDR_W, at or above NUM_PAGES*4096 returns fault code 1 (range) and physical address 0, whatever the table holds.
- R4: An in-window address whose entry is invalid returns fault code 2 (unmapped) and physical address 0.
- R5: The entry used is page index (addr - ap_base) >> 12. Neighbouring pages never alias.
- R6: A host write (tbl_we, with tbl_idx, tbl_valid and tbl_pfn) takes effect at its clock edge. A request accepted at that same edge gets the old mapping. Every later request gets the new one. Writing tbl_valid=0 invalidates that entry.
- R7: A tbl_inv_all pulse clears the valid flag of every entry, and it takes priority over a write in the same cycle.
- R8: While rsp_valid is high and rsp_ready is low, the response stays valid and its address and fault code do not change.
- R9: After a flush_req pulse, req_ready stays low until flush_done. flush_done pulses for one cycle, and only after a cycle in which no response was pending. With nothing in flight, it rises two edges after the flush_req edge.
- R10: After reset, rsp_valid and flush_done are low, req_ready is high, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ap_base | input | ADDR_W | Aperture base address, page aligned |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Aperture address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 range fault, 2 unmapped fault |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_valid | input | 1 | Valid flag to store |
| tbl_pfn | input | PA_W-12 | Physical frame number to store |
| tbl_inv_all | input | 1 | Clear all valid flags |
| flush_req | input | 1 | Request a drain of in-flight work |
| flush_done | output | 1 | One-cycle pulse: drain complete |

## Verification
A corrupt entry, or a wrong page index, shows up at the ports on the first request that lands in the affected page. The result appears one cycle after acceptance as a wrong frame number or a wrong fault code. To catch these, the bench sweeps every page at its first, middle and last byte and also probes the window edges. A stuck flush state shows as req_ready held low or flush_done missing at its exact cycle. A lost response under backpressure shows within the cycles that the hold is applied.

// File: rtl/aperture_pkg.sv
// Shared definitions for the aperture remapper.
// Assumes a fixed 4096-byte page.
package aperture_pkg;
    localparam int unsigned PAGE_SHIFT = 12;

    // Result code returned with every translation.
    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_RANGE    = 2'd1,
        FLT_UNMAPPED = 2'd2
    } fault_e;
endpackage

// File: rtl/ap_range_check.sv
// Window check and page split for one aperture address.
// Assumes ap_base is page aligned and the window fits in ADDR_W bits.
module ap_range_check
    import aperture_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_PAGES = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [ADDR_W-1:0]     base_i,
    output logic                  in_win_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [PAGE_SHIFT-1:0] off_o
);
    localparam logic [ADDR_W:0] WIN_BYTES = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

    logic [ADDR_W-1:0] rel;

    // Relative offset; an address below the base wraps to a large value.
    always_comb begin
        rel      = addr_i - base_i;
        in_win_o = ({1'b0, rel} < WIN_BYTES);
        idx_o    = rel[PAGE_SHIFT +: IDX_W];
        off_o    = rel[PAGE_SHIFT-1:0];
    end
endmodule

// File: rtl/ap_page_table.sv
// Register-held page table: one valid flag and frame number per page.
// A write lands at its clock edge. Reads are combinational, so a lookup
// in the same cycle as a write still sees the old contents.
module ap_page_table #(
    parameter int unsigned NUM_PAGES = 16,
    parameter int unsigned PFN_W     = 24,
    localparam int unsigned IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic             wvalid_i,
    input  logic [PFN_W-1:0] wpfn_i,
    input  logic             inv_all_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic             rvalid_o,
    output logic [PFN_W-1:0] rpfn_o
);
    logic [NUM_PAGES-1:0] valid_q;
    logic [PFN_W-1:0]     pfn_q [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        // Update one entry; invalidate-all beats a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                pfn_q[g]   <= '0;
            end else if (inv_all_i) begin
                valid_q[g] <= 1'b0;
            end else if (we_i && widx_i == IDX_W'(g)) begin
                valid_q[g] <= wvalid_i;
                pfn_q[g]   <= wpfn_i;
            end
        end
    end

    // Read port for the lookup path.
    always_comb begin
        rvalid_o = valid_q[ridx_i];
        rpfn_o   = pfn_q[ridx_i];
    end

    p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all_i |=> (valid_q == '0));
endmodule

// File: rtl/ap_flush_ctrl.sv
// Flush sequencer: holds a pending flag from flush_req until no response
// is in flight, then pulses done for one cycle.
module ap_flush_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_req_i,
    input  logic busy_i,
    output logic pend_o,
    output logic done_o
);
    logic pend_q, done_q;

    // Track the pending flush and raise done once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= pend_q && !busy_i;
            if (flush_req_i)
                pend_q <= 1'b1;
            else if (pend_q && !busy_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign done_o = done_q;

    p_done_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !$past(busy_i));
endmodule

// File: rtl/aperture_remap.sv
// Aperture page remapper top. Checks the window, looks up the page table
// and registers a physical address or fault one cycle after acceptance.
// Assumes ap_base is page aligned and stable while requests are active.
module aperture_remap
    import aperture_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PA_W      = 36,
    parameter int unsigned NUM_PAGES = 16,
    localparam int unsigned IDX_W    = $clog2(NUM_PAGES),
    localparam int unsigned PFN_W    = PA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ap_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [PFN_W-1:0]  tbl_pfn,
    input  logic              tbl_inv_all,
    input  logic              flush_req,
    output logic              flush_done
);
    logic                  in_win;
    logic [IDX_W-1:0]      idx;
    logic [PAGE_SHIFT-1:0] off;
    logic                  ent_valid;
    logic [PFN_W-1:0]      ent_pfn;
    logic                  flush_pend;
    logic                  accept;
    logic                  rsp_valid_q;
    logic [PA_W-1:0]       paddr_q;
    fault_e                fault_q;

    ap_range_check #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES)) u_range (
        .addr_i(req_addr), .base_i(ap_base),
        .in_win_o(in_win), .idx_o(idx), .off_o(off)
    );

    ap_page_table #(.NUM_PAGES(NUM_PAGES), .PFN_W(PFN_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we_i(tbl_we), .widx_i(tbl_idx), .wvalid_i(tbl_valid), .wpfn_i(tbl_pfn),
        .inv_all_i(tbl_inv_all), .ridx_i(idx),
        .rvalid_o(ent_valid), .rpfn_o(ent_pfn)
    );

    ap_flush_ctrl u_flush (
        .clk(clk), .rst_n(rst_n), .flush_req_i(flush_req),
        .busy_i(rsp_valid_q), .pend_o(flush_pend), .done_o(flush_done)
    );

    // Accept when not flushing and the response slot is free or emptying.
    always_comb begin
        req_ready = !flush_pend && (!rsp_valid_q || rsp_ready);
        accept    = req_valid && req_ready;
    end

    // Response register: load on accept, clear when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
        end else if (accept) begin
            rsp_valid_q <= 1'b1;
            if (!in_win) begin
                paddr_q <= '0;
                fault_q <= FLT_RANGE;
            end else if (!ent_valid) begin
                paddr_q <= '0;
                fault_q <= FLT_UNMAPPED;
            end else begin
                paddr_q <= {ent_pfn, off};
                fault_q <= FLT_NONE;
            end
        end else if (rsp_ready) begin
            rsp_valid_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
    p_no_accept_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend |-> !req_ready);
    p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
endmodule

// File: tb/aperture_remap_tb.sv
module aperture_remap_tb_top;
    localparam int unsigned AW = 24;
    localparam int unsigned PW = 28;
    localparam int unsigned NP = 8;
    localparam int unsigned IW = 3;
    localparam int unsigned FW = PW - 12;
    localparam logic [AW-1:0] BASE = 24'h3A_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1;
    logic [AW-1:0] req_addr = '0;
    logic [PW-1:0] rsp_paddr;
    logic [1:0] rsp_fault;
    logic tbl_we = 0, tbl_valid = 0, tbl_inv_all = 0, flush_req = 0, flush_done;
    logic [IW-1:0] tbl_idx = '0;
    logic [FW-1:0] tbl_pfn = '0;

    int checks = 0, errors = 0;
    logic          mv [NP];
    logic [FW-1:0] mp [NP];

    always #2 clk = ~clk;

    aperture_remap #(.ADDR_W(AW), .PA_W(PW), .NUM_PAGES(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ap_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_pfn(tbl_pfn),
        .tbl_inv_all(tbl_inv_all), .flush_req(flush_req), .flush_done(flush_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected result from the bench model of the table.
    task automatic expect_of(input logic [AW-1:0] a, output logic [1:0] f, output logic [PW-1:0] p);
        logic [AW-1:0] rel = a - BASE;
        int unsigned pg;
        p = '0;
        if (rel >= AW'(NP * 4096)) f = 2'd1;
        else begin
            pg = int'(rel >> 12);
            if (!mv[pg]) f = 2'd2;
            else begin
                f = 2'd0;
                p = {mp[pg], rel[11:0]};
            end
        end
    endtask

    task automatic wr(input int idx, input logic v, input logic [FW-1:0] pfn);
        @(negedge clk);
        tbl_we = 1; tbl_idx = IW'(idx); tbl_valid = v; tbl_pfn = pfn;
        @(negedge clk);
        tbl_we = 0;
        mv[idx] = v; mp[idx] = pfn;
    endtask

    task automatic xlate(input logic [AW-1:0] a, input string tag);
        logic [1:0] f;
        logic [PW-1:0] p;
        expect_of(a, f, p);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " fault"}, 64'(rsp_fault), 64'(f));
        chk({tag, " paddr"}, 64'(rsp_paddr), 64'(p));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [PW-1:0] held;
        for (int i = 0; i < NP; i++) begin mv[i] = 0; mp[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 rsp_valid", 64'(rsp_valid), 0);
        chk("R10 flush_done", 64'(flush_done), 0);
        chk("R10 req_ready", 64'(req_ready), 1);
        for (int i = 0; i < NP; i++) xlate(BASE + AW'(i * 4096 + 16), "R10 empty table");

        // R1/R4/R5: program all but pages 3 and 6, sweep every page
        for (int i = 0; i < NP; i++) wr(i, (i != 3 && i != 6), FW'(i * 4099 + 37));
        for (int i = 0; i < NP; i++) begin
            xlate(BASE + AW'(i * 4096),         "R1 R5 first byte");
            xlate(BASE + AW'(i * 4096 + 'hABC), "R1 R4 mid byte");
            xlate(BASE + AW'(i * 4096 + 'hFFF), "R5 last byte");
        end

        // R3: outside the window on both sides
        xlate(BASE - 1,                  "R3 below base");
        xlate(BASE - 24'h1000,           "R3 page below");
        xlate(BASE + AW'(NP * 4096),     "R3 at limit");
        xlate(BASE + AW'(NP * 4096 + 5), "R3 past limit");
        xlate(24'h00_0000,               "R3 zero");
        xlate(24'hFF_FFFF,               "R3 top");
        xlate(BASE + AW'(NP * 4096 - 1), "R1 last in window");

        // R6: write racing a lookup of the same page
        @(negedge clk);
        req_valid = 1; req_addr = BASE + 24'h2123;
        tbl_we = 1; tbl_idx = 3'd2; tbl_valid = 1; tbl_pfn = 16'hBEEF;
        @(negedge clk);
        req_valid = 0; tbl_we = 0;
        chk("R6 old mapping", 64'(rsp_paddr), 64'({mp[2], 12'h123}));
        mv[2] = 1; mp[2] = 16'hBEEF;
        xlate(BASE + 24'h2123, "R6 new mapping");
        wr(5, 0, 16'h1234);
        xlate(BASE + 24'h5010, "R6 invalidate by write");

        // R7: invalidate all wins over a simultaneous write
        @(negedge clk);
        tbl_inv_all = 1; tbl_we = 1; tbl_idx = 3'd1; tbl_valid = 1; tbl_pfn = 16'h7777;
        @(negedge clk);
        tbl_inv_all = 0; tbl_we = 0;
        for (int i = 0; i < NP; i++) mv[i] = 0;
        for (int i = 0; i < NP; i++) xlate(BASE + AW'(i * 4096 + 8), "R7 all invalid");

        // R8: backpressure holds the response
        wr(4, 1, 16'h0C0D);
        @(negedge clk);
        rsp_ready = 0; req_valid = 1; req_addr = BASE + 24'h4321;
        @(negedge clk);
        req_valid = 0;
        held = rsp_paddr;
        chk("R8 paddr", 64'(held), 64'({16'h0C0D, 12'h321}));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 still valid", 64'(rsp_valid), 1);
            chk("R8 stable", 64'(rsp_paddr), 64'(held));
            chk("R2 ready low when full", 64'(req_ready), 0);
        end
        rsp_ready = 1;
        @(negedge clk);
        chk("R8 consumed", 64'(rsp_valid), 0);

        // R9: flush with a response pending
        rsp_ready = 0; req_valid = 1; req_addr = BASE + 24'h4000;
        @(negedge clk);
        req_valid = 0; flush_req = 1;
        @(negedge clk);
        flush_req = 0;
        for (int k = 0; k < 3; k++) begin
            chk("R9 no done while busy", 64'(flush_done), 0);
            chk("R9 ready blocked", 64'(req_ready), 0);
            @(negedge clk);
        end
        rsp_ready = 1;
        @(negedge clk);
        chk("R9 drain edge", 64'(flush_done), 0);
        @(negedge clk);
        chk("R9 done pulse", 64'(flush_done), 1);
        @(negedge clk);
        chk("R9 done single", 64'(flush_done), 0);
        chk("R9 ready back", 64'(req_ready), 1);

        // R9: flush while idle
        flush_req = 1;
        @(negedge clk);
        flush_req = 0;
        chk("R9 idle first edge", 64'(flush_done), 0);
        @(negedge clk);
        chk("R9 idle done", 64'(flush_done), 1);
        @(negedge clk);
        xlate(BASE + 24'h4777, "R2 after flush");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule